// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block merges up to 31 peripheral interrupt inputs into one active-low interrupt request for a processor. Every input has a 3-bit priority and a trigger type, either edge or level. A small register bus sets these per input, sets the enable mask, reads the vector and writes the end of service. Reading the vector returns the source that wins at the moment of the read and marks it as taken. Writing the end-of-service address ends the current service.

Service nesting is kept in a hardware stack. Each accepted vector read pushes the level and source number being serviced. Each end-of-service write pops one entry. The request line is driven low only when a pending, enabled source ranks strictly above the level on top of the stack. With the stack empty, any pending source counts as above it. Requests of equal or lower rank wait until enough end-of-service writes have lowered the current level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A write to address n (0 to 31) sets the mode of source n: wdata[2:0] is the priority, where 7 ranks highest and 0 lowest, and wdata[4] selects the trigger (1 = rising edge, 0 = active-high level). Among pending enabled sources, the one with the highest priority wins.
- R2: When several pending enabled sources share the top priority, the lowest-numbered one wins.
- R3: Input 0 never takes part in arbitration. An input whose enable bit is clear never takes part either. A write to address 0x20 sets the enable bits that are 1 in wdata, and a write to 0x21 clears them.
- R4: A level source raised between clock edges drives irq_n low at the 3rd rising edge after it rises. An edge source does so at the 4th rising edge.
- R5: A read of address 0x22 (the vector) returns the number of the source that wins at the time of the read, zero-extended, on bus_rdata after the next rising edge.
- R6: irq_n is low only while the winning source's priority is strictly above the current service level. An equal or lower request stays held until end-of-service writes lower that level.
- R7: An accepted vector read pushes the winner's level and number onto an 8-entry stack. A write to 0x23 (end of service) pops one entry. A higher-priority source asserts irq_n while a lower one is in service.
- R8: An accepted vector read clears the pending flag of an edge source. A level source stays pending for as long as its input is high.
- R9: A vector read with no source above the current level returns the value last written to 0x24 (spurious vector) and leaves the stack unchanged.
- R10: An end-of-service write with an empty stack has no effect.
- R11: After reset, irq_n is high, bus_rdata is 0, all sources are disabled and the stack is empty.
- R12: irq_n goes high at the clock edge that accepts a vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt inputs; bit 0 is unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest state to reach from the ports is a nested service two levels deep in which a low-priority request is held. The popped level must then be shown to be the earlier service level and not idle. The bench pulses edge sources in a set order: a priority-2 service, a priority-6 service nested inside it and then ended, a held priority-1 request, and a priority-3 request that must still break through. In a similar way, a spurious read made during a service is exposed by counting how many end-of-service writes the held request needs before irq_n falls.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  // control addresses above the per-source mode window
  localparam int OFS_ENA_SET = 32;
  localparam int OFS_ENA_CLR = 33;
  localparam int OFS_VEC     = 34;
  localparam int OFS_EOI     = 35;
  localparam int OFS_SPUR    = 36;
  localparam int MODE_EDGE_BIT = 4;

  // a candidate outranks the service in progress when it exists and either
  // nothing is in service or its level is strictly higher
  function automatic logic outranks(input logic valid, input prio_t cand,
                                    input logic idle, input prio_t cur);
    return valid && (idle || (cand > cur));
  endfunction
endpackage

// File: rtl/nic_src_cond.sv
module nic_src_cond #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] edge_mode_i,
  input  logic [NSRC-1:0] ack_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic s1, s2, s3, ep, rise;
    assign rise = s2 & ~s3;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
        ep <= 1'b0;
      end else begin
        s1 <= raw_i[g];
        s2 <= s1;
        s3 <= s2;
        ep <= (ep & ~ack_i[g]) | rise;
      end
    end

    assign pend_o[g] = edge_mode_i[g] ? ep : s2;

    // R8
    edge_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && !rise) |=> !ep);
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        win_valid_o,
  output logic [SRC_W-1:0]            win_idx_o,
  output prio_t                       win_prio_o
);
  typedef struct packed {
    logic             v;
    logic [SRC_W-1:0] idx;
    prio_t            p;
  } win_t;

  // walk from the top index down; ">=" lets a lower index take over a tie
  function automatic win_t pick(input logic [NSRC-1:0] c,
                                input logic [NSRC-1:0][PRIO_W-1:0] pr);
    win_t w;
    w = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (c[i] && (!w.v || pr[i] >= w.p)) begin
        w.v   = 1'b1;
        w.idx = SRC_W'(i);
        w.p   = pr[i];
      end
    end
    return w;
  endfunction

  win_t win;
  always_comb begin
    win         = pick(cand_i, prio_i);
    win_valid_o = win.v;
    win_idx_o   = win.idx;
    win_prio_o  = win.p;
  end
endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SRC_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  prio_t            push_prio_i,
  input  logic [SRC_W-1:0] push_src_i,
  output logic [CNT_W-1:0] depth_o,
  output prio_t            top_prio_o,
  output logic [SRC_W-1:0] top_src_o
);
  localparam int ENT_W = PRIO_W + SRC_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] top_ptr;
  logic             empty, full;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign top_ptr = PTR_W'(cnt - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      unique case ({push_i, pop_i})
        2'b10: if (!full) begin
          mem[PTR_W'(cnt)] <= {push_prio_i, push_src_i};
          cnt <= cnt + CNT_W'(1);
        end
        2'b01: if (!empty) cnt <= cnt - CNT_W'(1);
        2'b11: begin
          if (!empty) mem[top_ptr] <= {push_prio_i, push_src_i};
          else begin
            mem[0] <= {push_prio_i, push_src_i};
            cnt    <= CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign depth_o    = cnt;
  assign top_prio_o = mem[top_ptr][ENT_W-1:SRC_W];
  assign top_src_o  = mem[top_ptr][SRC_W-1:0];

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> !full);

  // R6
  push_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !empty) |-> (push_prio_i > top_prio_o));

  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty) |=> (cnt == '0));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int STK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  localparam int SRC_W = $clog2(NSRC);
  localparam int CNT_W = $clog2(STK_DEPTH + 1);

  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NSRC-1:0]             edge_q, ena_q;
  logic [DATA_W-1:0]           spur_q, rdata_q;
  logic                        irq_n_q;

  // named bus events
  logic mode_we, ena_set, ena_clr, vec_rd, eoi_wr, spur_we;
  assign mode_we = bus_wr && (int'(bus_addr) < NSRC);
  assign ena_set = bus_wr && (bus_addr == ADDR_W'(OFS_ENA_SET));
  assign ena_clr = bus_wr && (bus_addr == ADDR_W'(OFS_ENA_CLR));
  assign eoi_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_EOI));
  assign spur_we = bus_wr && (bus_addr == ADDR_W'(OFS_SPUR));
  assign vec_rd  = bus_rd && (bus_addr == ADDR_W'(OFS_VEC));

  // arbitration and stack wires
  logic [NSRC-1:0]  pend, cand, ack;
  logic             win_valid, win_above, take, stk_idle;
  logic [SRC_W-1:0] win_idx, top_src;
  prio_t            win_prio, top_prio;
  logic [CNT_W-1:0] stk_depth;

  assign cand      = pend & ena_q & ~NSRC'(1);
  assign stk_idle  = (stk_depth == '0);
  assign win_above = outranks(win_valid, win_prio, stk_idle, top_prio);
  assign take      = vec_rd && win_above;
  assign ack       = take ? (NSRC'(1) << win_idx) : '0;

  nic_src_cond #(.NSRC(NSRC)) u_cond (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_i       (src_i),
    .edge_mode_i (edge_q),
    .ack_i       (ack),
    .pend_o      (pend)
  );

  nic_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .cand_i      (cand),
    .prio_i      (prio_q),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  nic_prio_stack #(.DEPTH(STK_DEPTH), .SRC_W(SRC_W)) u_stk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (take),
    .pop_i       (eoi_wr),
    .push_prio_i (win_prio),
    .push_src_i  (win_idx),
    .depth_o     (stk_depth),
    .top_prio_o  (top_prio),
    .top_src_o   (top_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      edge_q  <= '0;
      ena_q   <= '0;
      spur_q  <= '0;
      rdata_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (mode_we) begin
        prio_q[bus_addr[SRC_W-1:0]] <= bus_wdata[PRIO_W-1:0];
        edge_q[bus_addr[SRC_W-1:0]] <= bus_wdata[MODE_EDGE_BIT];
      end
      if (ena_set) ena_q <= ena_q | bus_wdata[NSRC-1:0];
      else if (ena_clr) ena_q <= ena_q & ~bus_wdata[NSRC-1:0];
      if (spur_we) spur_q <= bus_wdata;
      if (bus_rd) rdata_q <= vec_rd ? (win_above ? DATA_W'(win_idx) : spur_q) : '0;
      irq_n_q <= !(win_above && !take);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = irq_n_q;

  // R3
  win_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_idx != '0));

  // R1
  win_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_idx]);

  // R6
  irq_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_q |-> $past(win_above));

  // R12
  take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> irq_n_q);

  // R9
  spur_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !win_above && !eoi_wr) |=> $stable(stk_depth));

  // R7
  stk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stk_idle |-> (top_src != '0));
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam int A_SET = 32, A_CLR = 33, A_VEC = 34, A_EOI = 35, A_SPUR = 36;

  always #5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // mode word as stated in R1
  function automatic logic [31:0] mode_word(input int p, input bit edg);
    return (32'(edg) << 4) | 32'(p & 7);
  endfunction

  task automatic mode(input int s, input int p, input bit edg);
    wr(s, mode_word(p, edg));
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src[s] = 1'b1;
    @(negedge clk); src[s] = 1'b0;
  endtask

  task automatic eoi();
    wr(A_EOI, 32'h0);
  endtask

  task automatic t_reset();
    chk("R11 irq_n after reset", 32'(irq_n), 32'd1);
    chk("R11 rdata after reset", bus_rdata, 32'd0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    mode(5, 2, 1'b0);
    @(negedge clk); src[5] = 1'b1;
    settle(2); chk("R4 level not yet at edge 2", 32'(irq_n), 32'd1);
    settle(1); chk("R4 level asserted at edge 3", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R5 level vector", v, 32'd5);
    chk("R12 irq drops on accepted read", 32'(irq_n), 32'd1);
    settle(2); chk("R6 equal level held", 32'(irq_n), 32'd1);
    eoi(); settle(1);
    chk("R8 level still pending after service", 32'(irq_n), 32'd0);
    @(negedge clk); src[5] = 1'b0;
    settle(4); chk("R8 level gone with input", 32'(irq_n), 32'd1);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    mode(9, 4, 1'b1);
    @(negedge clk); src[9] = 1'b1;
    settle(3); chk("R4 edge not yet at edge 3", 32'(irq_n), 32'd1);
    settle(1); chk("R4 edge asserted at edge 4", 32'(irq_n), 32'd0);
    src[9] = 1'b0;
    rd(A_VEC, v);
    chk("R5 edge vector", v, 32'd9);
    eoi(); settle(2);
    chk("R8 edge pending cleared by ack", 32'(irq_n), 32'd1);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    mode(3, 1, 1'b0);
    mode(7, 6, 1'b0);
    @(negedge clk); src[3] = 1'b1;
    settle(4); chk("R1 low source requests", 32'(irq_n), 32'd0);
    @(negedge clk); src[7] = 1'b1;
    settle(4);
    rd(A_VEC, v);
    chk("R5 winner chosen at read time", v, 32'd7);
    @(negedge clk); src[7] = 1'b0;
    settle(4); chk("R6 lower request held in service", 32'(irq_n), 32'd1);
    eoi(); settle(1);
    chk("R6 held request released by eoi", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R1 lower source served next", v, 32'd3);
    @(negedge clk); src[3] = 1'b0;
    settle(4); eoi(); settle(2);
    chk("R1 idle after both", 32'(irq_n), 32'd1);
  endtask

  task automatic t_tie();
    logic [31:0] v;
    mode(12, 5, 1'b1);
    mode(20, 5, 1'b1);
    @(negedge clk); src[12] = 1'b1; src[20] = 1'b1;
    @(negedge clk); src[12] = 1'b0; src[20] = 1'b0;
    settle(4);
    rd(A_VEC, v);
    chk("R2 tie goes to lower number", v, 32'd12);
    settle(2); chk("R6 equal priority waits", 32'(irq_n), 32'd1);
    eoi(); settle(1);
    chk("R2 second of tie requests", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R2 second of tie vector", v, 32'd20);
    eoi(); settle(2);
  endtask

  task automatic t_nest();
    logic [31:0] v;
    mode(4, 2, 1'b1);
    mode(25, 6, 1'b1);
    mode(6, 1, 1'b1);
    mode(15, 3, 1'b1);
    pulse(4); settle(4);
    rd(A_VEC, v);
    chk("R7 outer vector", v, 32'd4);
    pulse(25); settle(4);
    chk("R7 higher source nests", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R7 nested vector", v, 32'd25);
    eoi();
    pulse(6); settle(4);
    chk("R7 popped level still blocks lower", 32'(irq_n), 32'd1);
    pulse(15); settle(4);
    chk("R7 above popped level requests", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R7 vector above popped level", v, 32'd15);
    eoi(); settle(2);
    chk("R7 outer service still blocks", 32'(irq_n), 32'd1);
    eoi(); settle(1);
    chk("R7 empty stack releases held", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R7 held vector", v, 32'd6);
    eoi(); settle(2);
  endtask

  task automatic t_spur();
    logic [31:0] v;
    wr(A_SPUR, 32'hA5);
    rd(A_VEC, v);
    chk("R9 idle read gives spurious", v, 32'hA5);
    mode(4, 3, 1'b1);
    mode(6, 1, 1'b1);
    pulse(4); settle(4);
    rd(A_VEC, v);
    chk("R9 service vector", v, 32'd4);
    pulse(6); settle(4);
    rd(A_VEC, v);
    chk("R9 blocked read gives spurious", v, 32'hA5);
    eoi(); settle(1);
    chk("R9 one eoi suffices, nothing pushed", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R9 held source after spurious", v, 32'd6);
    eoi(); settle(2);
  endtask

  task automatic t_mask();
    mode(30, 7, 1'b0);
    @(negedge clk); src[30] = 1'b1; src[0] = 1'b1;
    settle(5);
    chk("R3 disabled and input 0 ignored", 32'(irq_n), 32'd1);
    wr(A_SET, 32'h4000_0000); settle(1);
    chk("R3 enable set admits source", 32'(irq_n), 32'd0);
    wr(A_CLR, 32'h4000_0000); settle(1);
    chk("R3 enable clear removes source", 32'(irq_n), 32'd1);
    @(negedge clk); src[30] = 1'b0; src[0] = 1'b0;
    settle(4);
  endtask

  task automatic t_eoi_empty();
    logic [31:0] v;
    eoi(); eoi(); eoi();
    mode(2, 0, 1'b1);
    pulse(2); settle(4);
    chk("R10 empty eoi left stack idle", 32'(irq_n), 32'd0);
    rd(A_VEC, v);
    chk("R10 vector after empty eoi", v, 32'd2);
    eoi(); settle(2);
    chk("R10 single eoi ends service", 32'(irq_n), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    wr(A_SET, 32'hBFFF_FFFF);
    t_level();
    t_edge();
    t_prio();
    t_tie();
    t_nest();
    t_spur();
    t_mask();
    t_eoi_empty();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule